// File: doc/BRIEF.md
# Predicate and Conditional-Execution Controller

This block keeps a one-bit predicate and a short queue of condition entries for an in-order pipeline. It evaluates the seven compare operations on two 16-bit operands and writes the result into the predicate. An optional combine modifier can instead merge the result into the existing predicate with AND or OR for a programmed number of compares. It also decides, for every instruction, whether that instruction may commit.

A conditional-execute instruction loads up to eight condition entries. Each entry covers one following instruction. Entry 1 lets that instruction run only while the predicate is 1, and entry 0 lets it run only while the predicate is 0. Each retired instruction consumes one entry. The compare-and-predicate form of a compare loads a single "run if true" entry on its own.

The pipeline reads `exec_en` for the instruction presented in the current cycle. A squashed instruction has no effect on this block, but it still retires and still consumes its entry.

Top module: `pred_cex_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `pred` is 0, the condition queue is empty, `exec_en` is 1 and no combine modifier is active.
- R2: A compare updates `pred` at the next clock edge. The `cmp_op` codes are 0 equal, 1 not equal, 2 signed less-than, 3 unsigned less-than, 4 signed greater-or-equal, 5 unsigned greater-or-equal, and 6 "any", which is true when B&C is nonzero. Code 7 gives 0.
- R3: `p_write` loads `pred` from bit 0 of `p_wdata`. If a compare is presented in the same cycle, the write wins, the compare is dropped and the modifier count is unchanged.
- R4: `mod_load` arms a modifier for the next `mod_count` compares. `mod_sel` 1 gives P = P & result and `mod_sel` 2 gives P = P | result. Any other code, or a count of 0, gives plain replacement.
- R5: Each compare made while the modifier is armed uses up one step of the count. Once the count reaches zero, compares replace `pred` again.
- R6: `mask_load` loads the queue from `mask_bits` with length `mask_len`, and a length above 8 is clamped to 8. Bit 0 belongs to the next instruction. An entry of 1 gives `exec_en` equal to `pred`, and an entry of 0 gives `exec_en` equal to the inverse of `pred`.
- R7: Each `retire` consumes one entry while the queue is not empty. With an empty queue, `exec_en` is 1. A retire in the cycle that loads the queue consumes nothing, and a load with length 0 leaves the queue empty.
- R8: A compare with `cmp_setmask` set loads one "run if true" entry. The next instruction runs only if the new `pred` is 1, and the instruction after it runs unconditionally. If `mask_load` is presented in the same cycle, `mask_load` wins.
- R9: While `exec_en` is 0, the compare, `p_write`, `mask_load` and `mod_load` inputs have no effect. `retire` still consumes an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmp_valid | input | 1 | A compare is presented this cycle |
| cmp_op | input | 3 | Compare code |
| cmp_setmask | input | 1 | Compare also loads a one-entry "run if true" queue |
| opnd_b | input | 16 | Operand B |
| opnd_c | input | 16 | Operand C |
| mask_load | input | 1 | Load the condition queue |
| mask_bits | input | 8 | Condition entries, bit 0 first |
| mask_len | input | 4 | Number of valid entries (clamped to 8) |
| p_write | input | 1 | Write the predicate directly |
| p_wdata | input | 16 | Write data; bit 0 is used |
| mod_load | input | 1 | Arm a combine modifier |
| mod_sel | input | 2 | 1 = AND, 2 = OR, other = replace |
| mod_count | input | 4 | Number of compares the modifier covers |
| retire | input | 1 | Current instruction retires |
| pred | output | 1 | Predicate value |
| exec_en | output | 1 | Current instruction may commit |

## Verification
The stimulus presented in a cycle takes effect on `pred` and `exec_en` at exactly the next rising edge. `exec_en` is decoded without further registers from the registered queue head and predicate, so it settles in the same cycle as `pred`. The driver applies each instruction at the falling edge and pushes the expected pair into a queue. The monitor pops one pair 2 ns after every rising edge that follows a push, so each comparison lands one edge after its stimulus. Queue clamping, set-mask versus load priority, and squashed instructions are each followed entry by entry until the queue drains.

// File: rtl/pred_cex_pkg.sv
package pred_cex_pkg;
  typedef enum logic [2:0] {
    CMP_EQ   = 3'd0,
    CMP_NE   = 3'd1,
    CMP_LT   = 3'd2,
    CMP_LTU  = 3'd3,
    CMP_GE   = 3'd4,
    CMP_GEU  = 3'd5,
    CMP_ANY  = 3'd6,
    CMP_NONE = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    MOD_PLAIN = 2'd0,
    MOD_AND   = 2'd1,
    MOD_OR    = 2'd2,
    MOD_RSVD  = 2'd3
  } mod_e;
endpackage

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  output logic              result
);
  import pred_cex_pkg::*;

  cmp_op_e op_e;
  logic    eq_w;
  logic    lt_s_w;
  logic    lt_u_w;

  assign op_e   = cmp_op_e'(op);
  assign eq_w   = (opnd_b == opnd_c);
  assign lt_s_w = ($signed(opnd_b) < $signed(opnd_c));
  assign lt_u_w = (opnd_b < opnd_c);

  always_comb begin
    unique case (op_e)
      CMP_EQ:   result = eq_w;
      CMP_NE:   result = !eq_w;
      CMP_LT:   result = lt_s_w;
      CMP_LTU:  result = lt_u_w;
      CMP_GE:   result = !lt_s_w;
      CMP_GEU:  result = !lt_u_w;
      CMP_ANY:  result = |(opnd_b & opnd_c);
      default:  result = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_mask_queue.sv
module pred_mask_queue #(
  parameter int DEPTH = 8,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DEPTH-1:0] load_bits,
  input  logic [LEN_W-1:0] load_len,
  input  logic             single_en,
  input  logic             shift_en,
  output logic             head_bit,
  output logic             empty,
  output logic [LEN_W-1:0] len_out
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [DEPTH-1:0] bits_q, bits_d, bits_shr;
  logic [LEN_W-1:0] len_q, len_d;
  logic             pending;
  logic             upd_en;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_shr
      if (gi == DEPTH - 1) begin : g_top
        assign bits_shr[gi] = 1'b0;
      end else begin : g_mid
        assign bits_shr[gi] = bits_q[gi+1];
      end
    end
  endgenerate

  assign pending = (len_q != '0);
  assign upd_en  = load_en | single_en | (shift_en & pending);

  always_comb begin
    bits_d = bits_q;
    len_d  = len_q;
    if (load_en) begin
      bits_d = load_bits;
      len_d  = (load_len > LEN_MAX) ? LEN_MAX : load_len;
    end else if (single_en) begin
      bits_d = DEPTH'(1);
      len_d  = LEN_ONE;
    end else if (shift_en && pending) begin
      bits_d = bits_shr;
      len_d  = len_q - LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      len_q  <= '0;
    end else if (upd_en) begin
      bits_q <= bits_d;
      len_q  <= len_d;
    end
  end

  assign head_bit = bits_q[0];
  assign empty    = !pending;
  assign len_out  = len_q;
endmodule

// File: rtl/pred_state_reg.sv
module pred_state_reg #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             cmp_en,
  input  logic             cmp_res,
  input  logic             mod_ld,
  input  logic [1:0]       mod_sel,
  input  logic [CNT_W-1:0] mod_cnt,
  output logic             pred,
  output logic [CNT_W-1:0] cnt_left
);
  import pred_cex_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             pred_q, pred_d;
  mod_e             mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed;
  logic             merged;
  logic             pred_upd;
  logic             mod_upd;

  assign armed = (cnt_q != '0);

  always_comb begin
    merged = cmp_res;
    if (armed) begin
      unique case (mode_q)
        MOD_AND: merged = pred_q & cmp_res;
        MOD_OR:  merged = pred_q | cmp_res;
        default: merged = cmp_res;
      endcase
    end
  end

  assign pred_upd = wr_en | cmp_en;
  assign mod_upd  = mod_ld | (cmp_en & armed);

  always_comb begin
    pred_d = pred_q;
    if (wr_en)       pred_d = wr_bit;
    else if (cmp_en) pred_d = merged;
  end

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (mod_ld) begin
      mode_d = mod_e'(mod_sel);
      cnt_d  = mod_cnt;
    end else if (cmp_en && armed) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pred_q <= 1'b0;
    else if (pred_upd) pred_q <= pred_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MOD_PLAIN;
      cnt_q  <= '0;
    end else if (mod_upd) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pred     = pred_q;
  assign cnt_left = cnt_q;
endmodule

// File: rtl/pred_cex_ctrl.sv
module pred_cex_ctrl #(
  parameter int DATA_W     = 16,
  parameter int MASK_DEPTH = 8,
  parameter int CNT_W      = 4,
  parameter int LEN_W      = $clog2(MASK_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_valid,
  input  logic [2:0]            cmp_op,
  input  logic                  cmp_setmask,
  input  logic [DATA_W-1:0]     opnd_b,
  input  logic [DATA_W-1:0]     opnd_c,
  input  logic                  mask_load,
  input  logic [MASK_DEPTH-1:0] mask_bits,
  input  logic [LEN_W-1:0]      mask_len,
  input  logic                  p_write,
  input  logic [DATA_W-1:0]     p_wdata,
  input  logic                  mod_load,
  input  logic [1:0]            mod_sel,
  input  logic [CNT_W-1:0]      mod_count,
  input  logic                  retire,
  output logic                  pred,
  output logic                  exec_en
);
  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  logic             cmp_result;
  logic             head_bit;
  logic             q_empty;
  logic [LEN_W-1:0] q_len;
  logic [CNT_W-1:0] mod_left;
  logic             pw_fire;
  logic             cmp_fire;
  logic             ml_fire;
  logic             sm_fire;
  logic             mod_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign exec_en  = q_empty | (head_bit == pred);
  assign pw_fire  = exec_en & p_write;
  assign cmp_fire = exec_en & cmp_valid & ~p_write;
  assign ml_fire  = exec_en & mask_load;
  assign sm_fire  = cmp_fire & cmp_setmask & ~mask_load;
  assign mod_fire = exec_en & mod_load;

  pred_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
    .op     (cmp_op),
    .opnd_b (opnd_b),
    .opnd_c (opnd_c),
    .result (cmp_result)
  );

  pred_state_reg #(.CNT_W(CNT_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (pw_fire),
    .wr_bit   (p_wdata[0]),
    .cmp_en   (cmp_fire),
    .cmp_res  (cmp_result),
    .mod_ld   (mod_fire),
    .mod_sel  (mod_sel),
    .mod_cnt  (mod_count),
    .pred     (pred),
    .cnt_left (mod_left)
  );

  pred_mask_queue #(.DEPTH(MASK_DEPTH), .LEN_W(LEN_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en   (ml_fire),
    .load_bits (mask_bits),
    .load_len  (mask_len),
    .single_en (sm_fire),
    .shift_en  (retire),
    .head_bit  (head_bit),
    .empty     (q_empty),
    .len_out   (q_len)
  );
endmodule

// File: rtl/pred_cex_ctrl_chk.sv
module pred_cex_ctrl_chk #(
  parameter int DATA_W     = 16,
  parameter int MASK_DEPTH = 8,
  parameter int CNT_W      = 4,
  parameter int LEN_W      = 4
) (
  input logic              clk,
  input logic              rst_n_int,
  input logic              cmp_valid,
  input logic              cmp_setmask,
  input logic              p_write,
  input logic [DATA_W-1:0] p_wdata,
  input logic              mask_load,
  input logic [LEN_W-1:0]  mask_len,
  input logic              mod_load,
  input logic              pred,
  input logic              exec_en,
  input logic              cmp_result,
  input logic              cmp_fire,
  input logic [CNT_W-1:0]  mod_left,
  input logic [LEN_W-1:0]  q_len
);
  a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && p_write) |=> (pred == $past(p_wdata[0])));

  a_r2_plain_compare: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmp_fire && (mod_left == '0)) |=> (pred == $past(cmp_result)));

  a_r9_squash_keeps_pred: assert property (@(posedge clk) disable iff (!rst_n_int)
    !exec_en |=> $stable(pred));

  a_r8_single_entry: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && cmp_valid && cmp_setmask && !p_write && !mask_load) |=> (exec_en == pred));

  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n_int)
    (q_len <= LEN_W'(MASK_DEPTH)));

  a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmp_fire && (mod_left != '0) && !(exec_en && mod_load))
    |=> (mod_left == $past(mod_left) - CNT_W'(1)));

  a_r7_zero_len_runs: assert property (@(posedge clk) disable iff (!rst_n_int)
    (exec_en && mask_load && (mask_len == '0)) |=> exec_en);
endmodule

bind pred_cex_ctrl pred_cex_ctrl_chk #(
  .DATA_W(DATA_W), .MASK_DEPTH(MASK_DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n_int   (rst_n_int),
  .cmp_valid   (cmp_valid),
  .cmp_setmask (cmp_setmask),
  .p_write     (p_write),
  .p_wdata     (p_wdata),
  .mask_load   (mask_load),
  .mask_len    (mask_len),
  .mod_load    (mod_load),
  .pred        (pred),
  .exec_en     (exec_en),
  .cmp_result  (cmp_result),
  .cmp_fire    (cmp_fire),
  .mod_left    (mod_left),
  .q_len       (q_len)
);

// File: tb/pred_cex_ctrl_tb.sv
`timescale 1ns/1ps
module pred_cex_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cmp_valid;
  logic [2:0]  cmp_op;
  logic        cmp_setmask;
  logic [15:0] opnd_b;
  logic [15:0] opnd_c;
  logic        mask_load;
  logic [7:0]  mask_bits;
  logic [3:0]  mask_len;
  logic        p_write;
  logic [15:0] p_wdata;
  logic        mod_load;
  logic [1:0]  mod_sel;
  logic [3:0]  mod_count;
  logic        retire;
  logic        pred;
  logic        exec_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic  exp_pred[$];
  logic  exp_exec[$];
  string exp_tag[$];

  logic       m_p;
  logic [7:0] m_mask;
  int         m_len;
  logic [1:0] m_mode;
  int         m_cnt;

  pred_cex_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
    .cmp_setmask(cmp_setmask), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .mask_load(mask_load), .mask_bits(mask_bits), .mask_len(mask_len),
    .p_write(p_write), .p_wdata(p_wdata), .mod_load(mod_load),
    .mod_sel(mod_sel), .mod_count(mod_count), .retire(retire),
    .pred(pred), .exec_en(exec_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  function automatic logic cmp_model(input logic [2:0] op, input logic [15:0] b,
                                     input logic [15:0] c);
    case (op)
      3'd0: return b == c;
      3'd1: return b != c;
      3'd2: return $signed(b) < $signed(c);
      3'd3: return b < c;
      3'd4: return $signed(b) >= $signed(c);
      3'd5: return b >= c;
      3'd6: return |(b & c);
      default: return 1'b0;
    endcase
  endfunction

  task automatic clear_inputs();
    cmp_valid = 0; cmp_op = 0; cmp_setmask = 0; opnd_b = 0; opnd_c = 0;
    mask_load = 0; mask_bits = 0; mask_len = 0; p_write = 0; p_wdata = 0;
    mod_load = 0; mod_sel = 0; mod_count = 0; retire = 0;
  endtask

  task automatic step(input logic cv, input logic [2:0] op, input logic sm,
                      input logic [15:0] b, input logic [15:0] c,
                      input logic ml, input logic [7:0] mv, input logic [3:0] mlen,
                      input logic pw, input logic [15:0] pwd,
                      input logic mld, input logic [1:0] msel, input logic [3:0] mcnt,
                      input logic ret, input string tag);
    logic en, fire_cmp, r, np;
    @(negedge clk);
    cmp_valid = cv; cmp_op = op; cmp_setmask = sm; opnd_b = b; opnd_c = c;
    mask_load = ml; mask_bits = mv; mask_len = mlen; p_write = pw; p_wdata = pwd;
    mod_load = mld; mod_sel = msel; mod_count = mcnt; retire = ret;
    en       = (m_len == 0) || (m_mask[0] == m_p);
    fire_cmp = en && cv && !pw;
    r        = cmp_model(op, b, c);
    np       = m_p;
    if (en && pw) np = pwd[0];
    else if (fire_cmp) begin
      if (m_cnt > 0 && m_mode == 2'd1)      np = m_p & r;
      else if (m_cnt > 0 && m_mode == 2'd2) np = m_p | r;
      else                                  np = r;
    end
    if (en && mld) begin
      m_mode = msel; m_cnt = int'(mcnt);
    end else if (fire_cmp && m_cnt > 0) begin
      m_cnt--;
    end
    if (en && ml) begin
      m_mask = mv; m_len = (mlen > 4'd8) ? 8 : int'(mlen);
    end else if (fire_cmp && sm) begin
      m_mask = 8'd1; m_len = 1;
    end else if (ret && m_len > 0) begin
      m_mask = m_mask >> 1; m_len--;
    end
    m_p = np;
    exp_pred.push_back(m_p);
    exp_exec.push_back((m_len == 0) || (m_mask[0] == m_p));
    exp_tag.push_back(tag);
  endtask

  task automatic t_cmp(input logic [2:0] op, input logic [15:0] b, input logic [15:0] c,
                       input logic sm, input string tag);
    step(1, op, sm, b, c, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic t_pw(input logic [15:0] v, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, v, 0, 0, 0, 1, tag);
  endtask
  task automatic t_mod(input logic [1:0] sel, input logic [3:0] cnt, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, sel, cnt, 1, tag);
  endtask
  task automatic t_mask(input logic [7:0] bits, input logic [3:0] len, input string tag);
    step(0, 0, 0, 0, 0, 1, bits, len, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic t_ret(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_pred.size() != 0) begin
      string t;
      logic ep, ee;
      ep = exp_pred.pop_front();
      ee = exp_exec.pop_front();
      t  = exp_tag.pop_front();
      check(pred, ep, {t, " pred"});
      check(exec_en, ee, {t, " exec_en"});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    m_p = 0; m_mask = 0; m_len = 0; m_mode = 0; m_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(pred, 1'b0, "R1 reset pred");
    check(exec_en, 1'b1, "R1 reset exec_en");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(pred, 1'b0, "R1 after release pred");
    check(exec_en, 1'b1, "R1 after release exec_en");

    t_cmp(3'd0, 16'd5, 16'd5, 0, "R2 eq true");
    t_cmp(3'd1, 16'd5, 16'd5, 0, "R2 ne false");
    t_cmp(3'd2, 16'hFFFF, 16'd1, 0, "R2 lt signed");
    t_cmp(3'd3, 16'hFFFF, 16'd1, 0, "R2 ltu");
    t_cmp(3'd4, 16'h8000, 16'h7FFF, 0, "R2 ge signed");
    t_cmp(3'd5, 16'h8000, 16'h7FFF, 0, "R2 geu");
    t_cmp(3'd6, 16'h00F0, 16'h0F00, 0, "R2 any disjoint");
    t_cmp(3'd6, 16'h0110, 16'h0100, 0, "R2 any overlap");
    t_cmp(3'd7, 16'd3, 16'd3, 0, "R2 code7");

    t_pw(16'h0003, "R3 write one");
    t_pw(16'hFFFE, "R3 write zero");
    step(1, 3'd0, 0, 16'd1, 16'd2, 0, 0, 0, 1, 16'd1, 0, 0, 0, 1, "R3 write beats compare");

    t_mod(2'd1, 4'd1, "R4 arm and");
    t_cmp(3'd0, 16'd1, 16'd2, 0, "R4 and merge");
    t_cmp(3'd0, 16'd4, 16'd4, 0, "R5 and expired");
    t_pw(16'd0, "R4 setup");
    t_mod(2'd2, 4'd2, "R4 arm or");
    t_cmp(3'd0, 16'd1, 16'd2, 0, "R4 or false");
    t_cmp(3'd0, 16'd2, 16'd2, 0, "R4 or true");
    t_cmp(3'd0, 16'd1, 16'd2, 0, "R5 or expired");
    t_mod(2'd3, 4'd3, "R4 other code");
    t_cmp(3'd0, 16'd7, 16'd7, 0, "R4 other code replaces");

    t_pw(16'd1, "R6 setup");
    t_mask(8'b0000_0101, 4'd3, "R7 load no shift");
    t_ret("R6 entry0");
    t_ret("R6 entry1");
    t_ret("R7 drained");
    t_ret("R7 empty runs");

    t_mask(8'h00, 4'd2, "R9 setup");
    t_pw(16'd0, "R9 squashed write");
    t_cmp(3'd0, 16'd1, 16'd2, 0, "R9 squashed compare");

    t_cmp(3'd0, 16'd1, 16'd2, 1, "R8 false single");
    t_ret("R8 after single");
    t_cmp(3'd0, 16'd3, 16'd3, 1, "R8 true single");
    t_ret("R8 after true");

    step(1, 3'd0, 1, 16'd3, 16'd3, 1, 8'h00, 4'd2, 0, 0, 0, 0, 0, 1, "R8 load wins");
    t_ret("R8 load wins e1");
    t_ret("R8 load wins e2");

    t_mask(8'h00, 4'd15, "R6 clamp");
    for (int i = 0; i < 8; i++) t_ret("R6 clamp drain");
    t_mask(8'h00, 4'd0, "R7 zero length");
    t_mask(8'h00, 4'd1, "R9 setup2");
    t_mod(2'd1, 4'd2, "R9 squashed mod");
    t_cmp(3'd0, 16'd1, 16'd2, 0, "R9 mod not armed");

    @(negedge clk);
    clear_inputs();
    repeat (4) @(posedge clk);
    #5;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule